// File: doc/BRIEF.md
# USB Token and Handshake Packet Transmitter

This block assembles short USB packets and hands them, one byte at a time, to a byte-wide transceiver transmit port that uses a valid/ready pair. A caller presents a 4-bit packet identifier and either a device address with an endpoint number or an 11-bit frame number, then pulses a start strobe. The block then produces one of two packet shapes. For a token it sends three bytes: the identifier byte, followed by two bytes that carry the 11-bit field and its 5-bit CRC. For a handshake it sends only the identifier byte.

The CRC is computed in a single combinational step when the start strobe is accepted, and the finished bytes are captured in registers. The transceiver can then stall the transfer for any number of cycles while the caller's inputs are free to change. Bit serialisation, NRZI coding and bit stuffing belong to the transceiver and are not done here.

Top module: `usb_token_tx`

## Requirements
- R1: The first byte of every packet carries the identifier in bits 3:0 and its bitwise complement in bits 7:4.
- R2: For a token that is not start-of-frame, the 11-bit field is the address in field bits 6:0 and the endpoint in field bits 10:7. The second byte is field bits 7:0, so endpoint bit 0 lands in byte bit 7. The third byte holds field bits 10:8 in its bits 2:0.
- R3: The CRC uses the polynomial x^5+x^2+1 and a register seeded with all ones. Field bits are fed in starting with bit 0 and ending with bit 10. The complement of the result goes into bits 7:3 of the third byte, with CRC bit 4 in byte bit 3 and CRC bit 0 in byte bit 7.
- R4: Identifier 4'b0101 (start-of-frame) uses the frame number as the 11-bit field. The second byte is frame bits 7:0, and the third byte carries frame bits 10:8 in bits 2:0 beside the CRC.
- R5: Any identifier whose two low bits are 2'b10 (handshake class) produces a packet of only the identifier byte. All other identifiers produce three bytes.
- R6: Transmit-valid stays high for the whole packet and the data holds while transmit-ready is low. The data moves to the next byte only on an edge where ready is high. Valid falls on the edge that accepts the last byte.
- R7: Busy is high exactly while transmit-valid is high. A start strobe sampled while busy has no effect on the packet in flight or on any later output.
- R8: While reset is asserted, and after it is released with no start, transmit-valid and busy are low.
- R9: A start sampled on a clock edge while idle makes transmit-valid and busy high, with the identifier byte on the data port, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to build and send a packet |
| pid_i | input | 4 | Packet identifier |
| addr_i | input | 7 | Device address for tokens |
| endp_i | input | 4 | Endpoint number for tokens |
| frame_i | input | 11 | Frame number for start-of-frame |
| tx_ready_i | input | 1 | Transceiver accepts the current byte on this edge |
| tx_valid_o | output | 1 | A packet byte is being presented |
| tx_data_o | output | 8 | Current packet byte |
| busy_o | output | 1 | A packet is in flight |

## Verification
The identifier byte, transmit-valid and busy are due one edge after the start is sampled. Each later byte appears one edge after the edge on which ready accepted its predecessor. Valid and busy drop on the edge that accepts the last byte, so a new start can be taken one edge later. The bench drives inputs on falling edges and advances a queue-based reference model on each rising edge. It compares valid, busy and data on the following falling edge, so every expected value is taken in the exact cycle the design should present it, under constant, random and alternating ready patterns.

// File: rtl/usbtok_pkg.sv
package usbtok_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PID_W     = 4;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned EP_W      = 4;
  localparam int unsigned FIELD_W   = ADDR_W + EP_W;
  localparam int unsigned CRC_W     = 5;
  localparam int unsigned MAX_BYTES = 3;
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES);

  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_SEED = 5'b11111;

  localparam logic [PID_W-1:0] PID_SOF      = 4'b0101;
  localparam logic [1:0]       PID_HS_CLASS = 2'b10;

  typedef logic [BYTE_W-1:0] tok_byte_t;

  typedef struct packed {
    logic [IDX_W-1:0]                  last;
    logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes;
  } tok_pkt_t;

endpackage

// File: rtl/tokcrc_calc.sv
module tokcrc_calc #(
  parameter int unsigned DATA_W = 11,
  parameter int unsigned CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'b00101,
  parameter logic [CRC_W-1:0] SEED = 5'b11111
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  // Unrolled LFSR: data bit 0 enters first, bit DATA_W-1 last.
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = SEED;
    for (int i = 0; i < DATA_W; i++) begin
      fb  = acc[CRC_W-1] ^ data_i[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = acc;
  end

endmodule

// File: rtl/tokpkt_form.sv
module tokpkt_form
  import usbtok_pkg::*;
#(
  parameter int unsigned FLD_W = FIELD_W,
  parameter int unsigned CRC_BITS = CRC_W
) (
  input  logic [PID_W-1:0]  pid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EP_W-1:0]   endp_i,
  input  logic [FLD_W-1:0]  frame_i,
  output tok_pkt_t          pkt_o
);

  localparam int unsigned HI_W = FLD_W - BYTE_W;

  logic [FLD_W-1:0]    field;
  logic [CRC_BITS-1:0] crc_raw;
  logic [CRC_BITS-1:0] crc_inv;
  logic [CRC_BITS-1:0] crc_wire;
  logic                is_sof;
  logic                is_hs;

  assign is_sof = (pid_i == PID_SOF);
  assign is_hs  = (pid_i[1:0] == PID_HS_CLASS);
  assign field  = is_sof ? frame_i : {endp_i, addr_i};

  tokcrc_calc #(
    .DATA_W (FLD_W),
    .CRC_W  (CRC_BITS),
    .POLY   (CRC_POLY),
    .SEED   (CRC_SEED)
  ) u_crc (
    .data_i (field),
    .crc_o  (crc_raw)
  );

  assign crc_inv = ~crc_raw;

  // CRC goes out most significant bit first: reverse it into the byte.
  for (genvar g = 0; g < CRC_BITS; g++) begin : g_crc_rev
    assign crc_wire[g] = crc_inv[CRC_BITS-1-g];
  end

  always_comb begin
    pkt_o.bytes[0] = {~pid_i, pid_i};
    pkt_o.bytes[1] = field[BYTE_W-1:0];
    pkt_o.bytes[2] = {crc_wire, field[FLD_W-1 -: HI_W]};
    pkt_o.last     = is_hs ? IDX_W'(0) : IDX_W'(MAX_BYTES - 1);
  end

endmodule

// File: rtl/toktx_seq.sv
module toktx_seq
  import usbtok_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  tok_pkt_t   pkt_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output tok_byte_t  tx_data_o
);

  logic                              valid_q, valid_d;
  logic [IDX_W-1:0]                  idx_q, idx_d;
  logic [IDX_W-1:0]                  last_q;
  logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes_q;
  logic                              load;
  logic                              adv;
  logic                              done;

  assign load = start_i & ~valid_q;
  assign adv  = valid_q & tx_ready_i;
  assign done = adv & (idx_q == last_q);

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    if (load) begin
      valid_d = 1'b1;
      idx_d   = '0;
    end else if (done) begin
      valid_d = 1'b0;
    end else if (adv) begin
      idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      bytes_q <= pkt_i.bytes;
      last_q  <= pkt_i.last;
    end
  end

  always_comb begin
    tx_data_o = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (idx_q == IDX_W'(i)) tx_data_o = bytes_q[i];
    end
  end

  assign tx_valid_o = valid_q;

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !tx_ready_i |=> valid_q && $stable(tx_data_o)); // R6

  AST_DROP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && tx_ready_i && (idx_q == last_q) |=> !valid_q); // R6

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> idx_q <= last_q); // R5

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !valid_q |=> valid_q && (idx_q == '0)); // R9

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && start_i |=> $stable(last_q)); // R7

endmodule

// File: rtl/usb_token_tx.sv
module usb_token_tx
  import usbtok_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EP_W-1:0]   endp_i,
  input  logic [FIELD_W-1:0] frame_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              busy_o
);

  tok_pkt_t pkt;

  tokpkt_form #(
    .FLD_W    (FIELD_W),
    .CRC_BITS (CRC_W)
  ) u_form (
    .pid_i   (pid_i),
    .addr_i  (addr_i),
    .endp_i  (endp_i),
    .frame_i (frame_i),
    .pkt_o   (pkt)
  );

  toktx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pkt_i      (pkt),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  assign busy_o = tx_valid_o;

  AST_PID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> tx_data_o == {~$past(pid_i), $past(pid_i)}); // R1

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && tx_valid_o); // R9

endmodule

// File: tb/usb_token_tx_bench.sv
module usb_token_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  pid;
  logic [6:0]  addr;
  logic [3:0]  endp;
  logic [10:0] frame;
  logic        tx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 1;
  bit finished = 0;

  // reference model state
  logic [7:0] mq[$];
  bit  m_valid = 0;
  bit  m_first = 0;
  bit  m_hs    = 0;
  bit  m_sof   = 0;
  bit  m_ign   = 0;
  int  m_pos   = 0;

  usb_token_tx u_usb_token_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .pid_i      (pid),
    .addr_i     (addr),
    .endp_i     (endp),
    .frame_i    (frame),
    .tx_ready_i (tx_ready),
    .tx_valid_o (tx_valid),
    .tx_data_o  (tx_data),
    .busy_o     (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] ref_crc(input logic [10:0] d);
    logic [4:0] r;
    r = 5'h1f;
    for (int i = 0; i <= 10; i++)
      r = {r[3:0], 1'b0} ^ ({5{r[4] ^ d[i]}} & 5'b00101);
    return ~r;
  endfunction

  task automatic model_load();
    logic [10:0] f;
    logic [4:0]  c;
    mq.delete();
    m_sof = (pid == 4'b0101);
    m_hs  = (pid[1:0] == 2'b10);
    f = m_sof ? frame : {endp, addr};
    c = ref_crc(f);
    mq.push_back({~pid, pid});
    if (!m_hs) begin
      mq.push_back(f[7:0]);
      mq.push_back({c[0], c[1], c[2], c[3], c[4], f[10:8]});
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_valid = 0; m_first = 0; m_pos = 0; m_ign = 0;
    end else begin
      m_first = 0;
      if (m_valid) begin
        if (start) m_ign = 1;
        if (tx_ready) begin
          void'(mq.pop_front());
          m_pos++;
          if (mq.size() == 0) m_valid = 0;
        end
      end else if (start) begin
        model_load();
        m_valid = 1; m_first = 1; m_pos = 0; m_ign = 0;
      end
    end
  end

  task automatic report(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  // compare on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string tag;
      checks++;
      if (tx_valid !== m_valid) begin
        tag = m_first ? "R9" : (m_hs ? "R5" : "R6");
        report(tag, "valid", int'(tx_valid), int'(m_valid));
      end
      checks++;
      if (busy !== m_valid) report("R7", "busy", int'(busy), int'(m_valid));
      if (m_valid) begin
        checks++;
        if (tx_data !== mq[0]) begin
          if (m_ign) tag = "R7";
          else if (m_pos == 0) tag = "R1";
          else if (m_sof) tag = "R4";
          else if (m_pos == 2) tag = "R3";
          else tag = "R2";
          report(tag, "data", int'(tx_data), int'(mq[0]));
        end
      end
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      2: tx_ready = 1'($urandom % 2);
      default: tx_ready = ~tx_ready;
    endcase
  end

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      checks++;
      report("R6", "watchdog", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic fire(input logic [3:0] p, input logic [6:0] a,
                      input logic [3:0] e, input logic [10:0] f);
    @(negedge clk);
    pid = p; addr = a; endp = e; frame = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_valid) @(negedge clk);
  endtask

  initial begin
    start = 0; pid = 0; addr = 0; endp = 0; frame = 0; tx_ready = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    checks++; // R8 during reset
    if (tx_valid !== 1'b0 || busy !== 1'b0)
      report("R8", "reset outputs", int'({tx_valid, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R8 after release
    if (tx_valid !== 1'b0 || busy !== 1'b0)
      report("R8", "idle outputs", int'({tx_valid, busy}), 0);

    // tokens (R2, R3), start-of-frame (R4), handshakes (R5)
    rdy_mode = 1;
    fire(4'b0001, 7'h15, 4'he, 11'h000);
    fire(4'b1001, 7'h7f, 4'hf, 11'h000);
    fire(4'b1101, 7'h00, 4'h0, 11'h000);
    fire(4'b0101, 7'h00, 4'h0, 11'h7ff);
    fire(4'b0101, 7'h3c, 4'h1, 11'h5a3);
    fire(4'b0010, 7'h11, 4'h2, 11'h000);
    fire(4'b1010, 7'h11, 4'h2, 11'h000);
    fire(4'b1110, 7'h11, 4'h2, 11'h000);

    // alternating and random ready (R6)
    rdy_mode = 3;
    fire(4'b0001, 7'h2a, 4'h5, 11'h000);
    fire(4'b0101, 7'h00, 4'h0, 11'h123);
    rdy_mode = 2;
    for (int i = 0; i < 150; i++)
      fire(4'($urandom), 7'($urandom), 4'($urandom), 11'($urandom));

    // starts while busy are ignored (R7)
    rdy_mode = 0;
    @(negedge clk);
    pid = 4'b1001; addr = 7'h05; endp = 4'h3; start = 1'b1;
    @(negedge clk);
    pid = 4'b0101; frame = 11'h7aa; addr = 7'h70;
    repeat (4) @(negedge clk);
    start = 1'b0;
    rdy_mode = 1;
    while (m_valid) @(negedge clk);

    // start held high: back-to-back packets, inputs changing (R9, R7)
    rdy_mode = 2;
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 80; i++) begin
      pid = 4'($urandom); addr = 7'($urandom); endp = 4'($urandom); frame = 11'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    while (m_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule